// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache

This block is a small data cache placed between a processor's word load/store port and a slower, block-oriented memory. It holds sixteen lines of 64 bytes each, one kilobyte in total. A processor request carries a 32-bit byte address. The low six bits choose a byte within the block, the next four bits choose the line, and the upper 22 bits form the tag that is stored with the line. A read or write that finds a valid line with a matching tag completes in the same cycle it is presented.

On a miss the controller holds off the processor and first checks the line it is about to replace. If that victim holds modified data, the controller writes its whole block back to memory at the victim's own address. It then fetches the entire 64-byte block that contains the requested address, installs it, and finishes the original access from the refreshed line. Stores only ever touch the cached copy. Memory sees modified data only when a dirty line is evicted.

The processor must hold the request and its fields stable until ready is returned. The memory side transfers one whole block per request and completes it with a single-cycle acknowledge.

Top module: `dm_wb_cache`

## Requirements
- R1: After reset every line is invalid, `mem_req` is low, and `cpu_ready` is low while no request is presented.
- R2: A request whose line is valid and whose stored tag equals address bits [31:10] is a hit. `cpu_ready` is high in the same cycle as `cpu_req`, and a read returns the word selected by address bits [5:2] of that line.
- R3: On a miss `cpu_ready` stays low for the whole miss sequence, including while `mem_req` is high. It rises only in the cycle after the refill acknowledge, and the access then completes with the fetched data.
- R4: A write hit updates only the bytes whose `cpu_be` bit is set (bit n covers `cpu_wdata[8n+7:8n]`) and marks the line dirty, even when no enable bit is set.
- R5: A write hit causes no memory transaction, and memory contents stay unchanged until the line is evicted.
- R6: A miss on a valid dirty line first issues a write (`mem_we`=1) of the full 512-bit block to the address {old tag, index, 6'b0}, and only after its acknowledge issues the refill read.
- R7: A miss on an invalid or clean line issues only a refill read, with no write-back.
- R8: A write miss refills the block, then merges the store bytes into it and marks the line dirty, so that a later eviction writes back the merged block.
- R9: Address bits [9:6] alone select the line. Two addresses with the same index and different tags evict each other.
- R10: Every memory request address is block aligned (bits [5:0] zero), and `mem_req`, `mem_we` and `mem_addr` hold steady until `mem_ack`.
- R11: A reset clears all valid bits, so a previously cached block misses again and a stale dirty line is not written back.
- R12: Processor accesses are word aligned (address bits [1:0] zero while a request is presented).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor access request, held until ready |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address of the word access |
| cpu_wdata | input | 32 | Store data |
| cpu_be | input | 4 | Store byte enables |
| cpu_rdata | output | 32 | Load data, valid while ready is high |
| cpu_ready | output | 1 | Access completes in this cycle |
| mem_req | output | 1 | Block transfer request |
| mem_we | output | 1 | 1 = write-back of a block, 0 = refill read |
| mem_addr | output | 32 | Block-aligned memory address |
| mem_wdata | output | 512 | Victim block for write-back |
| mem_rdata | input | 512 | Refill block from memory |
| mem_ack | input | 1 | Transfer complete, single cycle |

## Verification
Checked on every cycle are the memory-side protocol rules: aligned addresses, requests held stable until acknowledged, and a write-back always followed by a refill read. Also checked every cycle are that ready never appears without a request or during a memory transfer, that ready follows a refill acknowledge, and that processor addresses are word aligned. Only the bench's scenarios can show the data-level effects. These include correct load data after hits and refills, byte-enable merging, memory staying untouched by write hits, the exact block and address written on a dirty eviction, the absence of write-back for clean lines, and the loss of all cached state across a reset.

// File: rtl/cache_pkg.sv
package cache_pkg;
  typedef enum logic [1:0] {
    ST_LOOKUP = 2'd0,
    ST_EVICT  = 2'd1,
    ST_FILL   = 2'd2,
    ST_FINISH = 2'd3
  } cache_state_e;
endpackage

// File: rtl/cache_addr_split.sv
module cache_addr_split #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 6,
  parameter int IDX_W  = 4,
  parameter int LANE_W = 2,
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W,
  localparam int WSEL_W = OFF_W - LANE_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [TAG_W-1:0]  tag,
  output logic [IDX_W-1:0]  idx,
  output logic [WSEL_W-1:0] word
);
  assign tag  = addr[ADDR_W-1 -: TAG_W];
  assign idx  = addr[OFF_W +: IDX_W];
  assign word = addr[LANE_W +: WSEL_W];
endmodule

// File: rtl/cache_lines.sv
module cache_lines #(
  parameter int LINES  = 16,
  parameter int TAG_W  = 22,
  parameter int DATA_W = 32,
  parameter int WORDS  = 16,
  localparam int IDX_W   = $clog2(LINES),
  localparam int WSEL_W  = $clog2(WORDS),
  localparam int BLOCK_W = DATA_W * WORDS,
  localparam int BYTES   = DATA_W / 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [IDX_W-1:0]   idx,
  input  logic               fill_en,
  input  logic [TAG_W-1:0]   fill_tag,
  input  logic [BLOCK_W-1:0] fill_data,
  input  logic               wr_en,
  input  logic [WSEL_W-1:0]  wr_word,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic [BYTES-1:0]   wr_be,
  output logic [TAG_W-1:0]   line_tag,
  output logic               line_valid,
  output logic               line_dirty,
  output logic [BLOCK_W-1:0] line_block
);
  logic [LINES-1:0]   valid_q;
  logic [LINES-1:0]   dirty_q;
  logic [TAG_W-1:0]   tag_q   [LINES];
  logic [BLOCK_W-1:0] block_q [LINES];

  // status bits: asynchronous reset, enabled by fill or store
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (fill_en) begin
      valid_q[idx] <= 1'b1;
      dirty_q[idx] <= 1'b0;
    end else if (wr_en) begin
      dirty_q[idx] <= 1'b1;
    end
  end

  // tag and data arrays carry no reset
  always_ff @(posedge clk) begin
    if (fill_en) begin
      tag_q[idx] <= fill_tag;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      block_q[idx] <= fill_data;
    end else if (wr_en) begin
      for (int b = 0; b < BYTES; b++) begin
        if (wr_be[b]) begin
          block_q[idx][int'(wr_word)*DATA_W + b*8 +: 8] <= wr_data[b*8 +: 8];
        end
      end
    end
  end

  assign line_tag   = tag_q[idx];
  assign line_valid = valid_q[idx];
  assign line_dirty = dirty_q[idx];
  assign line_block = block_q[idx];
endmodule

// File: rtl/cache_ctrl.sv
module cache_ctrl
  import cache_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req,
  input  logic         we,
  input  logic         hit,
  input  logic         victim_dirty,
  input  logic         mem_ack,
  output cache_state_e state,
  output logic         ready,
  output logic         wr_en,
  output logic         fill_en,
  output logic         mem_req,
  output logic         mem_we
);
  cache_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_LOOKUP: if (req && !hit) state_d = victim_dirty ? ST_EVICT : ST_FILL;
      ST_EVICT:  if (mem_ack) state_d = ST_FILL;
      ST_FILL:   if (mem_ack) state_d = ST_FINISH;
      ST_FINISH: state_d = ST_LOOKUP;
      default:   state_d = ST_LOOKUP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_LOOKUP;
    else        state_q <= state_d;
  end

  assign state   = state_q;
  assign ready   = req && hit && (state_q == ST_LOOKUP || state_q == ST_FINISH);
  assign wr_en   = ready && we;
  assign mem_req = (state_q == ST_EVICT) || (state_q == ST_FILL);
  assign mem_we  = (state_q == ST_EVICT);
  assign fill_en = (state_q == ST_FILL) && mem_ack;
endmodule

// File: rtl/dm_wb_cache.sv
module dm_wb_cache
  import cache_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int LINES       = 16,
  parameter int BLOCK_BYTES = 64,
  localparam int OFF_W   = $clog2(BLOCK_BYTES),
  localparam int IDX_W   = $clog2(LINES),
  localparam int TAG_W   = ADDR_W - IDX_W - OFF_W,
  localparam int BYTES   = DATA_W / 8,
  localparam int LANE_W  = $clog2(BYTES),
  localparam int WORDS   = BLOCK_BYTES / BYTES,
  localparam int WSEL_W  = $clog2(WORDS),
  localparam int BLOCK_W = BLOCK_BYTES * 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cpu_req,
  input  logic               cpu_we,
  input  logic [ADDR_W-1:0]  cpu_addr,
  input  logic [DATA_W-1:0]  cpu_wdata,
  input  logic [BYTES-1:0]   cpu_be,
  output logic [DATA_W-1:0]  cpu_rdata,
  output logic               cpu_ready,
  output logic               mem_req,
  output logic               mem_we,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [BLOCK_W-1:0] mem_wdata,
  input  logic [BLOCK_W-1:0] mem_rdata,
  input  logic               mem_ack
);
  logic [TAG_W-1:0]   req_tag;
  logic [IDX_W-1:0]   req_idx;
  logic [WSEL_W-1:0]  req_word;
  logic [TAG_W-1:0]   line_tag;
  logic               line_valid, line_dirty;
  logic [BLOCK_W-1:0] line_block;
  logic               hit, wr_en, fill_en;
  cache_state_e       state;

  cache_addr_split #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .LANE_W(LANE_W)
  ) u_split (
    .addr(cpu_addr), .tag(req_tag), .idx(req_idx), .word(req_word)
  );

  cache_lines #(
    .LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W), .WORDS(WORDS)
  ) u_lines (
    .clk(clk), .rst_n(rst_n), .idx(req_idx),
    .fill_en(fill_en), .fill_tag(req_tag), .fill_data(mem_rdata),
    .wr_en(wr_en), .wr_word(req_word), .wr_data(cpu_wdata), .wr_be(cpu_be),
    .line_tag(line_tag), .line_valid(line_valid), .line_dirty(line_dirty),
    .line_block(line_block)
  );

  assign hit = line_valid && (line_tag == req_tag);

  cache_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .req(cpu_req), .we(cpu_we), .hit(hit),
    .victim_dirty(line_valid && line_dirty), .mem_ack(mem_ack),
    .state(state), .ready(cpu_ready), .wr_en(wr_en), .fill_en(fill_en),
    .mem_req(mem_req), .mem_we(mem_we)
  );

  // write-back targets the victim's own tag; refill targets the request tag
  assign mem_addr  = {(state == ST_EVICT) ? line_tag : req_tag, req_idx, {OFF_W{1'b0}}};
  assign mem_wdata = line_block;
  assign cpu_rdata = line_block[int'(req_word)*DATA_W +: DATA_W];
endmodule

// File: rtl/dm_wb_cache_chk.sv
module dm_wb_cache_chk #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_req,
  input logic [1:0]        cpu_lane,
  input logic              cpu_ready,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] mem_addr
);
  p_ready_needs_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> cpu_req);

  p_no_ready_in_miss_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !cpu_ready);

  p_ready_after_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && mem_ack) |=> cpu_ready);

  p_wb_then_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_ack) |=> (mem_req && !mem_we));

  p_we_needs_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_req);

  p_aligned_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[OFF_W-1:0] == '0));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  p_word_aligned_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req |-> (cpu_lane == 2'b00));
endmodule

bind dm_wb_cache dm_wb_cache_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_lane(cpu_addr[1:0]),
  .cpu_ready(cpu_ready), .mem_req(mem_req), .mem_we(mem_we),
  .mem_ack(mem_ack), .mem_addr(mem_addr)
);

// File: tb/dm_wb_cache_bench.sv
module dm_wb_cache_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cpu_req = 1'b0, cpu_we = 1'b0;
  logic [31:0]  cpu_addr = '0, cpu_wdata = '0;
  logic [3:0]   cpu_be = '0;
  logic [31:0]  cpu_rdata;
  logic         cpu_ready, mem_req, mem_we;
  logic [31:0]  mem_addr;
  logic [511:0] mem_wdata;
  logic [511:0] mem_rdata = '0;
  logic         mem_ack = 1'b0;

  always #10 clk = ~clk;

  dm_wb_cache u_dm_wb_cache (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_be(cpu_be),
    .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  logic [31:0] memw [1024];
  logic [31:0] refw [1024];
  int n_chk = 0, n_bad = 0;
  int wb_cnt = 0, fill_cnt = 0, wait_cnt = 0;
  logic [31:0] last_wb_addr = '0;
  bit done = 0;

  function automatic logic [31:0] init_word(int i);
    return 32'h3C00_0000 + i * 32'h0001_0101;
  endfunction

  function automatic logic [31:0] mk_addr(int tg, int ix, int w);
    return (tg << 10) | (ix << 6) | (w << 2);
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // block memory model: two-cycle latency, one-cycle acknowledge
  initial begin
    forever begin
      @(negedge clk);
      if (mem_ack) mem_ack = 1'b0;
      else if (mem_req) begin
        if (wait_cnt == 1) begin
          wait_cnt = 0;
          for (int w = 0; w < 16; w++) begin
            if (mem_we) memw[int'(mem_addr[11:2]) + w] = mem_wdata[w*32 +: 32];
            else        mem_rdata[w*32 +: 32] = memw[int'(mem_addr[11:2]) + w];
          end
          if (mem_we) begin wb_cnt++; last_wb_addr = mem_addr; end
          else fill_cnt++;
          mem_ack = 1'b1;
        end else wait_cnt++;
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    cpu_req = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic access(input bit we, input logic [31:0] addr, input logic [31:0] wd,
                        input logic [3:0] be, output logic [31:0] rd, output int cyc);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd; cpu_be = be;
    cyc = 0;
    rd = '0;
    forever begin
      #2;
      if (cpu_ready) begin rd = cpu_rdata; break; end
      if (cyc > 100) break;
      @(negedge clk);
      cyc++;
    end
    @(posedge clk);
  endtask

  task automatic idle();
    @(negedge clk);
    cpu_req = 1'b0; cpu_we = 1'b0;
  endtask

  task automatic ref_write(logic [31:0] addr, logic [31:0] wd, logic [3:0] be);
    for (int b = 0; b < 4; b++)
      if (be[b]) refw[int'(addr[11:2])][b*8 +: 8] = wd[b*8 +: 8];
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    int cyc, f0, w0;
    for (int i = 0; i < 1024; i++) begin memw[i] = init_word(i); refw[i] = init_word(i); end
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #2;
    // R1: quiet after reset
    check(!cpu_ready && !mem_req, "R1 reset idle", {30'd0, cpu_ready, mem_req}, 32'd0);

    // R7/R3: cold misses on every line, tag 0, no write-back
    for (int ix = 0; ix < 16; ix++) begin
      f0 = fill_cnt; w0 = wb_cnt;
      access(0, mk_addr(0, ix, ix), '0, '0, rd, cyc);
      check(cyc > 0, "R3 miss stalls", cyc, 32'd1);
      check(rd == refw[ix*16 + ix], "R3 refill data", rd, refw[ix*16 + ix]);
      check(fill_cnt == f0 + 1 && wb_cnt == w0, "R7 clean miss one fill",
            fill_cnt - f0 + 16 * (wb_cnt - w0), 32'd1);
    end
    // R2: every word of every line hits in the request cycle
    for (int ix = 0; ix < 16; ix++)
      for (int w = 0; w < 16; w++) begin
        access(0, mk_addr(0, ix, w), '0, '0, rd, cyc);
        check(cyc == 0, "R2 hit same cycle", cyc, 32'd0);
        check(rd == refw[ix*16 + w], "R2 hit data", rd, refw[ix*16 + w]);
      end

    // R4/R5: write hits with every byte-enable pattern
    for (int ix = 0; ix < 16; ix++) begin
      logic [31:0] a, wd;
      a = mk_addr(0, ix, (ix * 5) % 16);
      wd = 32'hA1B2_C3D4 ^ (ix * 32'h1111_1111);
      f0 = fill_cnt; w0 = wb_cnt;
      access(1, a, wd, ix[3:0], rd, cyc);
      ref_write(a, wd, ix[3:0]);
      check(cyc == 0, "R4 write hit same cycle", cyc, 32'd0);
      check(fill_cnt == f0 && wb_cnt == w0, "R5 no memory traffic on write hit",
            (fill_cnt - f0) + (wb_cnt - w0), 32'd0);
      check(memw[int'(a[11:2])] == init_word(int'(a[11:2])), "R5 memory untouched",
            memw[int'(a[11:2])], init_word(int'(a[11:2])));
      access(0, a, '0, '0, rd, cyc);
      check(rd == refw[int'(a[11:2])], "R4 byte merge", rd, refw[int'(a[11:2])]);
    end

    // R6/R9: same index, new tag evicts the dirty line first
    for (int ix = 0; ix < 16; ix++) begin
      int wi;
      wi = ix * 16 + (ix * 5) % 16;
      f0 = fill_cnt; w0 = wb_cnt;
      access(0, mk_addr(1, ix, 3), '0, '0, rd, cyc);
      check(wb_cnt == w0 + 1, "R6 dirty eviction writes back", wb_cnt - w0, 32'd1);
      check(last_wb_addr == mk_addr(0, ix, 0), "R6 write-back address",
            last_wb_addr, mk_addr(0, ix, 0));
      check(memw[wi] == refw[wi], "R6 written-back word", memw[wi], refw[wi]);
      check(fill_cnt == f0 + 1, "R9 conflict refill", fill_cnt - f0, 32'd1);
      check(rd == refw[256 + ix*16 + 3], "R9 new tag data", rd, refw[256 + ix*16 + 3]);
    end

    // R7: clean lines are replaced without write-back
    for (int ix = 0; ix < 16; ix++) begin
      w0 = wb_cnt;
      access(0, mk_addr(2, ix, 15), '0, '0, rd, cyc);
      check(wb_cnt == w0, "R7 clean eviction no write-back", wb_cnt - w0, 32'd0);
      check(rd == refw[512 + ix*16 + 15], "R7 data", rd, refw[512 + ix*16 + 15]);
    end

    // R8: write misses refill, merge, then write back the merged block
    for (int ix = 0; ix < 16; ix++) begin
      logic [31:0] a, wd;
      a = mk_addr(3, ix, ix);
      wd = 32'h0F1E_2D3C + ix;
      f0 = fill_cnt; w0 = wb_cnt;
      access(1, a, wd, 4'b0101, rd, cyc);
      ref_write(a, wd, 4'b0101);
      check(fill_cnt == f0 + 1 && wb_cnt == w0, "R8 write miss refills",
            (fill_cnt - f0) + 16 * (wb_cnt - w0), 32'd1);
      access(0, a, '0, '0, rd, cyc);
      check(rd == refw[int'(a[11:2])], "R8 merged store", rd, refw[int'(a[11:2])]);
      access(0, mk_addr(0, ix, 0), '0, '0, rd, cyc);
      check(memw[int'(a[11:2])] == refw[int'(a[11:2])], "R8 merged block written back",
            memw[int'(a[11:2])], refw[int'(a[11:2])]);
      check(memw[int'(a[11:2]) ^ 1] == refw[int'(a[11:2]) ^ 1], "R8 neighbour word",
            memw[int'(a[11:2]) ^ 1], refw[int'(a[11:2]) ^ 1]);
    end

    // dirty line then reset: R11
    access(1, mk_addr(0, 7, 2), 32'hDEAD_BEEF, 4'hF, rd, cyc);
    idle();
    do_reset();
    f0 = fill_cnt; w0 = wb_cnt;
    access(0, mk_addr(0, 7, 2), '0, '0, rd, cyc);
    check(fill_cnt == f0 + 1, "R11 miss after reset", fill_cnt - f0, 32'd1);
    check(wb_cnt == w0, "R11 stale dirty line dropped", wb_cnt - w0, 32'd0);
    check(rd == refw[7*16 + 2], "R11 data from memory", rd, refw[7*16 + 2]);
    idle();
    @(negedge clk); #2;
    check(!cpu_ready && !mem_req, "R1 idle without request", {30'd0, cpu_ready, mem_req}, 32'd0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule